// File: doc/BRIEF.md
# ULPI Link Register Access Engine

This engine sits on the link side of a ULPI PHY connection and runs entirely in the 60 MHz ULPI clock domain. The host issues a single request. The request carries a direction, an 8-bit register address and, for writes, a byte. The engine then runs the full bus exchange with the PHY: it drives the transmit command byte, any extra address byte and the data byte, ends writes with a stop pulse, and handles bus turnaround on reads. When the exchange finishes, the engine raises a sticky completion flag. For reads, the returned byte is held on `rd_data`.

The addressing mode comes from the address value. Addresses below a threshold (default 0x2F) go straight into the 6-bit field of the command byte. Any address at or above the threshold is sent in extended form: the command field carries an escape code and the full address follows as a second byte. This extra byte adds one clock to the exchange.

The engine can also wake the PHY. A host pulse marks the PHY as suspended. The next accepted request first clears that mark and waits a fixed number of clocks before the command byte goes out. A watchdog ends any exchange that fails to finish within a fixed number of clocks and reports a timeout.

Top module: `ulpi_reg_engine`

## Requirements
- R1: An address below EXT_BASE (default 0x2F) is sent in the low 6 bits of the command byte. An address at or above EXT_BASE puts 6'h2F in those bits and then sends the full 8-bit address as the next byte. `acc_ext` shows which form the current or last access used (1 = extended).
- R2: Bits 7:6 of the command byte are 2'b10 for a register write and 2'b11 for a register read.
- R3: When the PHY raises `ulpi_nxt` in the first cycle each byte is shown, `done` rises a fixed number of clock edges after the edge that accepts the request. That number is 5 for an immediate write, 6 for an immediate read, 6 for an extended write and 7 for an extended read.
- R4: Each command, address or data byte stays unchanged on `ulpi_data_o` until the PHY raises `ulpi_nxt`. Every cycle without `ulpi_nxt` adds exactly one clock to the latency.
- R5: A write ends with `ulpi_stp` high for exactly one clock while `ulpi_data_o` is 0, and the PHY register receives the written byte.
- R6: A read waits one turnaround cycle after `ulpi_dir` rises and samples `ulpi_data_i` in the cycle after that. It then waits for `ulpi_dir` to fall. The sampled byte appears on `rd_data` when `done` rises.
- R7: A request is accepted only when `busy` is low. A `req_valid` pulse while busy has no effect on the bus or on any PHY register.
- R8: If `phy_suspend` is high when a request is accepted, it is lowered before the command byte is driven, and the latency grows by exactly WAKE_CYC clocks.
- R9: An exchange still unfinished TMO_CYC clock edges after acceptance is abandoned at that edge. `timeout` goes high and `busy` goes low, while `done` stays low.
- R10: After reset, `busy`, `done`, `timeout`, `ulpi_stp` and `phy_suspend` are 0 and `ulpi_data_o` is 0.
- R11: `ulpi_data_oe` is low in every cycle where `ulpi_dir` is high.
- R12: `done` and `timeout` stay set until the next accepted request, which clears both. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock (60 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | PHY register address |
| req_wdata | input | 8 | Byte to write |
| susp_set | input | 1 | Marks the PHY as suspended |
| busy | output | 1 | An exchange is in progress |
| done | output | 1 | Sticky completion flag |
| timeout | output | 1 | Sticky watchdog expiry flag |
| rd_data | output | 8 | Byte returned by the last read |
| acc_ext | output | 1 | Current or last access used extended addressing |
| phy_suspend | output | 1 | PHY suspend control, high while suspended |
| ulpi_dir | input | 1 | PHY owns the data bus |
| ulpi_nxt | input | 1 | PHY accepts the current byte or is presenting data |
| ulpi_data_i | input | 8 | Data bus driven by the PHY |
| ulpi_data_o | output | 8 | Data bus driven by the link |
| ulpi_data_oe | output | 1 | Link drives the data bus |
| ulpi_stp | output | 1 | Stop strobe to the PHY |

## Verification
The assertions assume a well-behaved PHY in three ways:
- `ulpi_nxt` is raised only while a link byte is being shown.
- `ulpi_dir` goes high only after the command byte of a read is taken.
- `ulpi_dir` returns low on its own.

Host inputs are assumed to change only between clock edges. The bench PHY model follows these rules in every pass. It responds at the falling edge and keeps its own register file. It stays silent on the bus except for one deliberate "dead PHY" pass, which exists to reach the watchdog. The stall setting delays `ulpi_nxt` by the same count on every byte, so the expected latency is computed as a plain sum.

// File: rtl/ulpi_reg_pkg.sv
package ulpi_reg_pkg;

    localparam int BYTE_W = 8;

    localparam logic [1:0] OP_WRITE = 2'b10;
    localparam logic [1:0] OP_READ  = 2'b11;
    localparam logic [5:0] EXT_ESC  = 6'h2F;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PREP,
        S_WAKE,
        S_CMD,
        S_EADDR,
        S_WDATA,
        S_STP,
        S_WAIT_DIR,
        S_RDATA,
        S_WAIT_LOW,
        S_FIN
    } bus_state_t;

    typedef struct packed {
        logic              write;
        logic              ext;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } acc_req_t;

    // Transmit command byte: opcode in the top two bits, address or escape below.
    function automatic logic [BYTE_W-1:0] cmd_byte(input acc_req_t r);
        logic [1:0] op;
        logic [5:0] fld;
        op  = r.write ? OP_WRITE : OP_READ;
        fld = r.ext ? EXT_ESC : r.addr[5:0];
        return {op, fld};
    endfunction

endpackage

// File: rtl/ulpi_req_capture.sv
module ulpi_req_capture
    import ulpi_reg_pkg::*;
#(
    parameter logic [BYTE_W-1:0] EXT_BASE = 8'h2F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idle,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BYTE_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_wdata,
    output logic              accept,
    output acc_req_t          req_q
);

    assign accept = idle && req_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q.write <= req_write;
            req_q.ext   <= (req_addr >= EXT_BASE);
            req_q.addr  <= req_addr;
            req_q.wdata <= req_wdata;
        end
    end

    AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(req_q)); // R7

endmodule

// File: rtl/ulpi_susp_ctrl.sv
module ulpi_susp_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic susp_set,
    input  logic wake_clr,
    output logic phy_suspend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phy_suspend <= 1'b0;
        end else if (wake_clr) begin
            phy_suspend <= 1'b0;
        end else if (susp_set) begin
            phy_suspend <= 1'b1;
        end
    end

    AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wake_clr |=> !phy_suspend); // R8

endmodule

// File: rtl/ulpi_tmo_watch.sv
module ulpi_tmo_watch #(
    parameter int TMO_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    output logic expire
);

    localparam int            CW   = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt <= '0;
        end else if (active && (cnt != LAST)) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign expire = active && (cnt == LAST);

    AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (rst)
        expire |=> !active); // R9

endmodule

// File: rtl/ulpi_bus_fsm.sv
module ulpi_bus_fsm
    import ulpi_reg_pkg::*;
#(
    parameter int WAKE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  acc_req_t          req,
    input  logic              phy_suspend,
    input  logic              expire,
    input  logic              ulpi_dir,
    input  logic              ulpi_nxt,
    input  logic [BYTE_W-1:0] ulpi_data_i,
    output logic              idle,
    output logic              busy,
    output logic              wake_clr,
    output logic [BYTE_W-1:0] data_o,
    output logic              stp,
    output logic              done,
    output logic              timeout,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int            WW        = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
    localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CYC - 1);

    bus_state_t        st, st_nx;
    logic [WW-1:0]     wcnt;
    logic              abort;
    logic [BYTE_W-1:0] cmd;

    assign cmd      = cmd_byte(req);
    assign idle     = (st == S_IDLE);
    assign busy     = !idle;
    assign stp      = (st == S_STP);
    assign wake_clr = (st == S_PREP) && phy_suspend;
    assign abort    = expire && (st != S_FIN) && (st != S_IDLE);

    // Byte presented to the PHY.
    always_comb begin
        unique case (st)
            S_CMD:   data_o = cmd;
            S_EADDR: data_o = req.addr;
            S_WDATA: data_o = req.wdata;
            default: data_o = '0;
        endcase
    end

    // Next-state logic.
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:     if (accept) st_nx = S_PREP;
            S_PREP:     st_nx = phy_suspend ? S_WAKE : S_CMD;
            S_WAKE:     if (wcnt == WAKE_LAST) st_nx = S_CMD;
            S_CMD: begin
                if (ulpi_nxt) begin
                    if (req.ext)        st_nx = S_EADDR;
                    else if (req.write) st_nx = S_WDATA;
                    else                st_nx = S_WAIT_DIR;
                end
            end
            S_EADDR:    if (ulpi_nxt) st_nx = req.write ? S_WDATA : S_WAIT_DIR;
            S_WDATA:    if (ulpi_nxt) st_nx = S_STP;
            S_STP:      st_nx = S_FIN;
            S_WAIT_DIR: if (ulpi_dir) st_nx = S_RDATA;
            S_RDATA:    st_nx = S_WAIT_LOW;
            S_WAIT_LOW: if (!ulpi_dir) st_nx = S_FIN;
            S_FIN:      st_nx = S_IDLE;
            default:    st_nx = S_IDLE;
        endcase
        if (abort) st_nx = S_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            wcnt    <= '0;
            done    <= 1'b0;
            timeout <= 1'b0;
            rd_data <= '0;
        end else begin
            st <= st_nx;
            if (st == S_WAKE) wcnt <= wcnt + WW'(1);
            else              wcnt <= '0;
            if (accept) begin
                done    <= 1'b0;
                timeout <= 1'b0;
            end
            if (st == S_FIN) done    <= 1'b1;
            if (abort)       timeout <= 1'b1;
            if (st == S_RDATA) rd_data <= ulpi_data_i;
        end
    end

    AST_HOLD_UNTIL_NXT: assert property (@(posedge clk) disable iff (rst)
        ((st inside {S_CMD, S_EADDR, S_WDATA}) && !ulpi_nxt && !expire) |=> $stable(data_o)); // R4
    AST_STP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stp |=> !stp); // R5
    AST_WAKE_BEFORE_CMD: assert property (@(posedge clk) disable iff (rst)
        (st == S_CMD) |-> !phy_suspend); // R8
    AST_DONE_XOR_TMO: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout)); // R12
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> idle); // R3

endmodule

// File: rtl/ulpi_reg_engine.sv
module ulpi_reg_engine
    import ulpi_reg_pkg::*;
#(
    parameter logic [7:0] EXT_BASE = 8'h2F,
    parameter int         WAKE_CYC = 4,
    parameter int         TMO_CYC  = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [7:0] req_addr,
    input  logic [7:0] req_wdata,
    input  logic       susp_set,
    output logic       busy,
    output logic       done,
    output logic       timeout,
    output logic [7:0] rd_data,
    output logic       acc_ext,
    output logic       phy_suspend,
    input  logic       ulpi_dir,
    input  logic       ulpi_nxt,
    input  logic [7:0] ulpi_data_i,
    output logic [7:0] ulpi_data_o,
    output logic       ulpi_data_oe,
    output logic       ulpi_stp
);

    logic     idle;
    logic     accept;
    logic     wake_clr;
    logic     expire;
    acc_req_t req_q;

    // The link releases the bus whenever the PHY claims it.
    assign ulpi_data_oe = !ulpi_dir;
    assign acc_ext      = req_q.ext;

    ulpi_req_capture #(.EXT_BASE(EXT_BASE)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .idle      (idle),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .accept    (accept),
        .req_q     (req_q)
    );

    ulpi_susp_ctrl u_susp (
        .clk         (clk),
        .rst         (rst),
        .susp_set    (susp_set),
        .wake_clr    (wake_clr),
        .phy_suspend (phy_suspend)
    );

    ulpi_tmo_watch #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .active (busy),
        .expire (expire)
    );

    ulpi_bus_fsm #(.WAKE_CYC(WAKE_CYC)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .req         (req_q),
        .phy_suspend (phy_suspend),
        .expire      (expire),
        .ulpi_dir    (ulpi_dir),
        .ulpi_nxt    (ulpi_nxt),
        .ulpi_data_i (ulpi_data_i),
        .idle        (idle),
        .busy        (busy),
        .wake_clr    (wake_clr),
        .data_o      (ulpi_data_o),
        .stp         (ulpi_stp),
        .done        (done),
        .timeout     (timeout),
        .rd_data     (rd_data)
    );

endmodule

// File: tb/sim_ulpi_reg_engine.sv
module sim_ulpi_reg_engine;

    localparam int CLK_PERIOD = 16;
    localparam int WAKE       = 4;
    localparam int TMO        = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0, req_write = 1'b0, susp_set = 1'b0;
    logic [7:0] req_addr = '0, req_wdata = '0;
    logic       busy, done, timeout, acc_ext, phy_suspend;
    logic [7:0] rd_data;
    logic       ulpi_dir = 1'b0, ulpi_nxt = 1'b0;
    logic [7:0] ulpi_data_i = '0;
    logic [7:0] ulpi_data_o;
    logic       ulpi_data_oe, ulpi_stp;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ulpi_reg_engine #(.EXT_BASE(8'h2F), .WAKE_CYC(WAKE), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .susp_set(susp_set),
        .busy(busy), .done(done), .timeout(timeout), .rd_data(rd_data),
        .acc_ext(acc_ext), .phy_suspend(phy_suspend), .ulpi_dir(ulpi_dir),
        .ulpi_nxt(ulpi_nxt), .ulpi_data_i(ulpi_data_i), .ulpi_data_o(ulpi_data_o),
        .ulpi_data_oe(ulpi_data_oe), .ulpi_stp(ulpi_stp)
    );

    // ---------------- PHY model (acts on the falling edge) ----------------
    typedef enum int {P_IDLE, P_EADDR, P_WDATA, P_STP, P_TURN, P_DATA, P_BACK} phy_st_t;
    phy_st_t    pst = P_IDLE;
    logic [7:0] phy_regs [256];
    logic [7:0] seen_cmd, m_addr, m_wdata;
    logic       seen_ext, m_wr;
    int         nxt_hold = 0, hold_cnt = 0, stp_cnt = 0, stp_bad = 0, oe_bad = 0;
    logic       phy_dead = 1'b0;

    initial for (int i = 0; i < 256; i++) phy_regs[i] = 8'h00;

    always @(negedge clk) begin
        ulpi_nxt = 1'b0;
        if (rst) begin
            pst = P_IDLE; ulpi_dir = 1'b0; ulpi_data_i = '0;
        end else begin
            if (ulpi_stp) stp_cnt++;
            case (pst)
                P_IDLE: if (ulpi_data_oe && ulpi_data_o[7] && !phy_dead) begin
                    if (hold_cnt < nxt_hold) hold_cnt++;
                    else begin
                        hold_cnt = 0; ulpi_nxt = 1'b1;
                        seen_cmd = ulpi_data_o; seen_ext = 1'b0;
                        m_wr     = (ulpi_data_o[7:6] == 2'b10);
                        m_addr   = {2'b00, ulpi_data_o[5:0]};
                        if (ulpi_data_o[5:0] == 6'h2F) pst = P_EADDR;
                        else pst = m_wr ? P_WDATA : P_TURN;
                    end
                end
                P_EADDR: begin
                    if (hold_cnt < nxt_hold) hold_cnt++;
                    else begin
                        hold_cnt = 0; ulpi_nxt = 1'b1;
                        m_addr = ulpi_data_o; seen_ext = 1'b1;
                        pst = m_wr ? P_WDATA : P_TURN;
                    end
                end
                P_WDATA: begin
                    if (hold_cnt < nxt_hold) hold_cnt++;
                    else begin
                        hold_cnt = 0; ulpi_nxt = 1'b1;
                        m_wdata = ulpi_data_o; pst = P_STP;
                    end
                end
                P_STP: begin
                    if (ulpi_stp && ulpi_data_o == 8'h00) phy_regs[m_addr] = m_wdata;
                    else stp_bad++;
                    pst = P_IDLE;
                end
                P_TURN: begin ulpi_dir = 1'b1; pst = P_DATA; end
                P_DATA: begin ulpi_data_i = phy_regs[m_addr]; pst = P_BACK; end
                P_BACK: begin ulpi_dir = 1'b0; ulpi_data_i = '0; pst = P_IDLE; end
                default: pst = P_IDLE;
            endcase
        end
    end

    always @(posedge clk) if (ulpi_dir && ulpi_data_oe) oe_bad++;

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) ^ 8'h5C);
    endfunction

    int first_done;

    // Latency = clock edges from the accepting edge until done/timeout seen.
    task automatic access(input logic wr, input logic [7:0] a, input logic [7:0] d, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        stp_cnt = 0; hold_cnt = 0;
        @(posedge clk);
        lat = 0;
        first_done = -1;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            if (first_done < 0) first_done = int'(done) + 2 * int'(timeout);
            if (done || timeout) break;
            @(posedge clk);
            lat++;
        end while (lat < 1000);
    endtask

    task automatic run_pair(input int a, input int h);
        int lat, exp_lat;
        logic ext;
        ext = (a >= 8'h2F);
        nxt_hold = h;
        access(1'b1, 8'(a), pat(a), lat);
        exp_lat = 5 + int'(ext) + h * (2 + int'(ext));
        chk($sformatf("R3/R4 write latency addr %0d hold %0d", a, h), lat, exp_lat);
        chk("R12 done cleared at accept", first_done, 0);
        chk($sformatf("R5 reg written addr %0d", a), int'(phy_regs[a]), int'(pat(a)));
        chk("R5 stp one cycle", stp_cnt, 1);
        chk("R2 write opcode", int'(seen_cmd[7:6]), 2);
        chk("R1 cmd address field", int'(seen_cmd[5:0]), ext ? 47 : (a % 64));
        chk("R1 extended byte sent", int'(seen_ext), int'(ext));
        if (ext) chk("R1 extended address byte", int'(m_addr), a);
        chk("R1 acc_ext", int'(acc_ext), int'(ext));
        access(1'b0, 8'(a), 8'h00, lat);
        exp_lat = 6 + int'(ext) + h * (1 + int'(ext));
        chk($sformatf("R3/R4 read latency addr %0d hold %0d", a, h), lat, exp_lat);
        chk($sformatf("R6 read data addr %0d", a), int'(rd_data), int'(pat(a)));
        chk("R2 read opcode", int'(seen_cmd[7:6]), 3);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int lat;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk("R10 busy after reset", int'(busy), 0);
        chk("R10 done after reset", int'(done), 0);
        chk("R10 timeout after reset", int'(timeout), 0);
        chk("R10 stp after reset", int'(ulpi_stp), 0);
        chk("R10 suspend after reset", int'(phy_suspend), 0);
        chk("R10 bus idle after reset", int'(ulpi_data_o), 0);

        // Sweep of all addresses with a prompt PHY.
        for (int a = 0; a < 256; a++) run_pair(a, 0);

        // Stalling PHY on addresses around the mode boundary.
        run_pair(8'h00, 2);
        run_pair(8'h2E, 2);
        run_pair(8'h2F, 1);
        run_pair(8'hC3, 3);
        nxt_hold = 0;

        // R7: a request while busy is ignored.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h10; req_wdata = 8'hA7;
        @(negedge clk) req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h20; req_wdata = 8'h99;
        @(negedge clk) req_valid = 1'b0;
        for (int i = 0; i < 20 && !done; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R7 first request written", int'(phy_regs[8'h10]), 8'hA7);
        chk("R7 second request ignored", int'(phy_regs[8'h20]), int'(pat(8'h20)));
        chk("R7 engine idle afterwards", int'(busy), 0);
        chk("R12 done stays set", int'(done), 1);

        // R8: wake from suspend.
        @(negedge clk) susp_set = 1'b1;
        @(negedge clk) susp_set = 1'b0;
        chk("R8 suspend marked", int'(phy_suspend), 1);
        access(1'b1, 8'h05, 8'h3C, lat);
        chk("R8 wake latency", lat, 5 + WAKE);
        chk("R8 suspend cleared", int'(phy_suspend), 0);
        chk("R8 write after wake", int'(phy_regs[8'h05]), 8'h3C);

        // R9: dead PHY, then recovery.
        phy_dead = 1'b1;
        access(1'b1, 8'h07, 8'h11, lat);
        chk("R9 timeout latency", lat, TMO);
        chk("R9 timeout flag", int'(timeout), 1);
        chk("R9 done low on timeout", int'(done), 0);
        chk("R9 idle after timeout", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk("R12 timeout stays set", int'(timeout), 1);
        phy_dead = 1'b0;
        access(1'b0, 8'h07, 8'h00, lat);
        chk("R12 flags cleared at accept", first_done, 0);
        chk("R12 timeout cleared", int'(timeout), 0);
        chk("R6 read after recovery", int'(rd_data), int'(pat(8'h07)));

        chk("R11 oe low while dir high", oe_bad, 0);
        chk("R5 stp pattern on every write", stp_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule